// File: doc/BRIEF.md
# Configurable Audio Serial Clock Generator

This block produces the bit clock for an audio serial port. Its behaviour is set by a single 32-bit configuration word. A 3-bit code picks one of four candidate clock levels: the clock pin, a synthesizer clock, an oscillator clock or a PLL-derived clock. Any unused code selects a constant low.

The chosen level drives a compare-and-toggle divider, which can be bypassed. In master mode the block drives the bypassed or divided clock onto the clock pin and raises the pin output enable. In slave mode the internal clock comes from the pin, optionally inverted. A separate TDM clock, also optionally inverted, can replace the generated clock on the way to the serial block.

All candidate clocks are treated as levels that are oversampled by the block's own fast clock `clk`. The divider counts rising edges of the selected level that it sees on `clk`, so its counter and divided output are ordinary registers in the `clk` domain. The mode, inversion and override paths are combinational on the input levels. The block has no data stream, so every pin is a plain control or clock-level signal and no valid/ready handshake applies.

Top module: `audio_sclk_gen`

## Requirements
- R1: `pin_oe` equals configuration bit 0 (1 = master, 0 = slave). In slave mode `pin_clk_out` is 0. In master mode `pin_clk_out` carries the master clock.
- R2: In slave mode with no TDM override, `serial_clk` equals `pin_in` XOR configuration bit 1.
- R3: With bit 2 (bypass) set, the master clock is the selected source level itself, passed combinationally.
- R4: With bypass clear, the master clock is a divided level. It toggles on the D+1-th rising edge of the selected source after the previous toggle or counter clear, where D is configuration bits 18:3. This gives a divide ratio of 2*(D+1).
- R5: Configuration bits 21:19 select the source: 1 = `pin_in`, 2 = `synth_clk`, 3 = `osc_clk`, 4 = `pll_clk`. Codes 0 and 5 to 7 give constant 0.
- R6: With bit 22 set, `serial_clk` carries the TDM clock instead of the generated (master or slave) clock. With bit 22 clear, `serial_clk` carries the generated clock.
- R7: Bit 23 inverts the TDM clock on `serial_clk` only while bit 22 is set. With bit 22 clear, bit 23 has no effect on any output.
- R8: A change of D or of the source code clears the divider counter. The divided level does not toggle in the `clk` cycle where the change is seen. The next toggle comes on the D+1-th source rising edge after that cycle.
- R9: While `rst_n` is low, the counter is cleared and the divided level is 0.
- R10: With D = 0, the divided level toggles on every rising edge of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock for the divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word |
| pin_in | input | 1 | Level read from the clock pin |
| synth_clk | input | 1 | Synthesizer clock level |
| osc_clk | input | 1 | Oscillator clock level |
| pll_clk | input | 1 | PLL-derived clock level |
| tdm_clk | input | 1 | Alternative TDM clock level |
| serial_clk | output | 1 | Clock sent to the serial block |
| pin_clk_out | output | 1 | Clock driven onto the pin in master mode |
| pin_oe | output | 1 | Pin output enable |

## Verification
Two divider events can fall in the same `clk` cycle: a configuration change that clears the counter, and a source rising edge that would otherwise advance the counter or toggle the output. The random phase changes D mid-run while the sources toggle freely, so the two collide often. A directed case also changes D between edges and then counts output toggles. In every cycle a bench model that gives the change priority judges the result on both clock outputs.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int CFG_W  = 32;
  localparam int DIV_W  = 16;
  localparam int SEL_W  = 3;
  localparam int N_SRC  = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_PIN   = 3'd1,
    SRC_SYNTH = 3'd2,
    SRC_OSC   = 3'd3,
    SRC_PLL   = 3'd4
  } src_code_e;

  typedef struct packed {
    logic [CFG_W-DIV_W-SEL_W-6:0] spare;
    logic                         tdm_inv;
    logic                         tdm_sel;
    logic [SEL_W-1:0]             src;
    logic [DIV_W-1:0]             div;
    logic                         bypass;
    logic                         pin_inv;
    logic                         master;
  } cfg_t;
endpackage

// File: rtl/acg_src_sel.sv
module acg_src_sel
  import acg_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] code,
  input  logic [NS-1:0] cand,
  output logic          lvl
);
  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (code == SW'(i + 1)) lvl = cand[i];
    end
  end
endmodule

// File: rtl/acg_divider.sv
module acg_divider #(
  parameter int DW = acg_pkg::DIV_W,
  parameter int SW = acg_pkg::SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_lvl,
  input  logic [DW-1:0] div_val,
  input  logic [SW-1:0] src_code,
  output logic          div_clk
);
  logic          src_d;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] div_q;
  logic [SW-1:0] code_q;
  logic          tgl_q;
  logic          src_edge;
  logic          cfg_change;

  assign src_edge   = src_lvl & ~src_d;
  assign cfg_change = (div_val != div_q) || (src_code != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      code_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      src_d  <= src_lvl;
      div_q  <= div_val;
      code_q <= src_code;
      if (cfg_change) begin
        cnt_q <= '0;
      end else if (src_edge) begin
        if (cnt_q == div_q) begin
          cnt_q <= '0;
          tgl_q <= ~tgl_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign div_clk = tgl_q;

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !src_edge |=> $stable(tgl_q)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q); // R4
  AST_CHANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (cnt_q == '0) && $stable(tgl_q)); // R8
  AST_D0_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_edge && !cfg_change && div_q == '0) |=> (tgl_q != $past(tgl_q))); // R10
endmodule

// File: rtl/acg_out_mux.sv
module acg_out_mux (
  input  logic master,
  input  logic pin_inv,
  input  logic bypass,
  input  logic tdm_sel,
  input  logic tdm_inv,
  input  logic src_lvl,
  input  logic div_clk,
  input  logic pin_in,
  input  logic tdm_clk,
  output logic serial_clk,
  output logic pin_clk_out,
  output logic pin_oe
);
  logic mst_clk;
  logic slv_clk;
  logic gen_clk;
  logic alt_clk;

  assign mst_clk     = bypass ? src_lvl : div_clk;
  assign slv_clk     = pin_in ^ pin_inv;
  assign gen_clk     = master ? mst_clk : slv_clk;
  assign alt_clk     = tdm_clk ^ tdm_inv;
  assign serial_clk  = tdm_sel ? alt_clk : gen_clk;
  assign pin_clk_out = master & mst_clk;
  assign pin_oe      = master;
endmodule

// File: rtl/audio_sclk_gen.sv
module audio_sclk_gen
  import acg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             pin_in,
  input  logic             synth_clk,
  input  logic             osc_clk,
  input  logic             pll_clk,
  input  logic             tdm_clk,
  output logic             serial_clk,
  output logic             pin_clk_out,
  output logic             pin_oe
);
  cfg_t             cfg;
  logic [N_SRC-1:0] cand;
  logic             src_lvl;
  logic             div_clk;

  assign cfg  = cfg_t'(cfg_word);
  assign cand = {pll_clk, osc_clk, synth_clk, pin_in};

  acg_src_sel #(.NS(N_SRC), .SW(SEL_W)) u_sel (
    .code (cfg.src),
    .cand (cand),
    .lvl  (src_lvl)
  );

  acg_divider #(.DW(DIV_W), .SW(SEL_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_lvl  (src_lvl),
    .div_val  (cfg.div),
    .src_code (cfg.src),
    .div_clk  (div_clk)
  );

  acg_out_mux u_mux (
    .master      (cfg.master),
    .pin_inv     (cfg.pin_inv),
    .bypass      (cfg.bypass),
    .tdm_sel     (cfg.tdm_sel),
    .tdm_inv     (cfg.tdm_inv),
    .src_lvl     (src_lvl),
    .div_clk     (div_clk),
    .pin_in      (pin_in),
    .tdm_clk     (tdm_clk),
    .serial_clk  (serial_clk),
    .pin_clk_out (pin_clk_out),
    .pin_oe      (pin_oe)
  );

  AST_SLAVE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.master && !cfg.tdm_sel) |-> (serial_clk == (pin_in ^ cfg.pin_inv))); // R2
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_clk_out); // R1
endmodule

// File: tb/sim_audio_sclk_gen.sv
`timescale 1ns/1ps
module sim_audio_sclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        pin_in = 0, synth_clk = 0, osc_clk = 0, pll_clk = 0, tdm_clk = 0;
  logic        serial_clk, pin_clk_out, pin_oe;

  int total = 0;
  int bad = 0;
  int tgl_cnt = 0;
  logic last_pin = 1'b0;

  logic        m_src_d;
  logic [15:0] m_cnt, m_div_q;
  logic [2:0]  m_code_q;
  logic        m_tgl;

  always #2.5 clk = ~clk;

  audio_sclk_gen u0 (.*);

  function automatic logic sel_lvl(input logic [2:0] c);
    case (c)
      3'd1: return pin_in;
      3'd2: return synth_clk;
      3'd3: return osc_clk;
      3'd4: return pll_clk;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mst_exp();
    return cfg_word[2] ? sel_lvl(cfg_word[21:19]) : m_tgl;
  endfunction

  function automatic logic ser_exp();
    if (cfg_word[22]) return tdm_clk ^ cfg_word[23];
    return cfg_word[0] ? mst_exp() : (pin_in ^ cfg_word[1]);
  endfunction

  function automatic string ser_tag();
    if (cfg_word[22]) return cfg_word[23] ? "R7" : "R6";
    if (!cfg_word[0]) return "R2";
    return cfg_word[2] ? "R3" : "R4";
  endfunction

  function automatic string pin_tag();
    if (cfg_word[2]) return "R3";
    return (cfg_word[18:3] == 16'd0) ? "R10" : "R4";
  endfunction

  // reference model of the divider, built from R4, R8, R9, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src_d <= 0; m_cnt <= 0; m_div_q <= 0; m_code_q <= 0; m_tgl <= 0;
    end else begin
      m_src_d  <= sel_lvl(cfg_word[21:19]);
      m_div_q  <= cfg_word[18:3];
      m_code_q <= cfg_word[21:19];
      if (cfg_word[18:3] != m_div_q || cfg_word[21:19] != m_code_q) m_cnt <= 0;
      else if (sel_lvl(cfg_word[21:19]) && !m_src_d) begin
        if (m_cnt == m_div_q) begin m_cnt <= 0; m_tgl <= ~m_tgl; end
        else m_cnt <= m_cnt + 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1", "pin_oe", pin_oe, cfg_word[0]);
    chk(cfg_word[0] ? pin_tag() : "R1", "pin_clk_out", pin_clk_out, cfg_word[0] & mst_exp());
    chk(ser_tag(), "serial_clk", serial_clk, ser_exp());
    if (pin_clk_out !== last_pin) tgl_cnt++;
    last_pin = pin_clk_out;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic osc_edges(input int n);
    for (int i = 0; i < n; i++) begin
      osc_clk = 1'b1; step();
      osc_clk = 1'b0; step();
    end
  endtask

  function automatic logic [31:0] mk(input logic tinv, input logic tsel, input logic [2:0] src,
                                     input logic [15:0] d, input logic byp, input logic inv,
                                     input logic ms);
    return {8'd0, tinv, tsel, src, d, byp, inv, ms};
  endfunction

  task automatic count_run(input logic [15:0] d, input int edges, input int expc, input string tag);
    cfg_word = mk(0, 0, 3'd3, d, 0, 0, 1);
    osc_clk = 0;
    step(); step();
    tgl_cnt = 0;
    osc_edges(edges);
    step();
    total++;
    if (tgl_cnt != expc) begin
      bad++;
      $display("FAIL %s toggles actual=%0d expected=%0d", tag, tgl_cnt, expc);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R9: reset state, master with divider path
    cfg_word = mk(0, 0, 3'd3, 16'd1, 0, 0, 1);
    osc_clk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "pin_clk_out in reset", pin_clk_out, 1'b0);
    chk("R1", "pin_oe in reset", pin_oe, 1'b1);
    osc_clk = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R4 divide ratio and R10 divide-by-2
    count_run(16'd4, 60, 12, "R4");
    count_run(16'd0, 10, 10, "R10");
    count_run(16'd2, 9, 3, "R4");

    // R8: change D mid-count, counter clears
    cfg_word = mk(0, 0, 3'd3, 16'd3, 0, 0, 1);
    step(); step();
    tgl_cnt = 0;
    osc_edges(2);
    cfg_word = mk(0, 0, 3'd3, 16'd1, 0, 0, 1);
    step();
    osc_edges(2);
    step();
    total++;
    if (tgl_cnt != 1) begin
      bad++;
      $display("FAIL R8 toggles actual=%0d expected=1", tgl_cnt);
    end
    // R8: change coincident with a source rising edge, no toggle there
    cfg_word = mk(0, 0, 3'd3, 16'd0, 0, 0, 1);
    step(); step();
    tgl_cnt = 0;
    osc_clk = 1'b1;
    cfg_word = mk(0, 0, 3'd3, 16'd5, 0, 0, 1);
    step(); step();
    total++;
    if (tgl_cnt != 0) begin
      bad++;
      $display("FAIL R8 coincident toggles actual=%0d expected=0", tgl_cnt);
    end
    osc_clk = 1'b0;
    step();

    // R5: source decode under bypass
    for (int c = 0; c < 8; c++) begin
      cfg_word = mk(0, 0, 3'(c), 16'd0, 1, 0, 1);
      {pll_clk, osc_clk, synth_clk, pin_in} = 4'b1111;
      step();
      chk("R5", "all-high source", pin_clk_out, (c >= 1 && c <= 4));
      {pll_clk, osc_clk, synth_clk, pin_in} = 4'b0000;
      if (c >= 1 && c <= 4) begin
        pin_in    = (c == 1); synth_clk = (c == 2);
        osc_clk   = (c == 3); pll_clk   = (c == 4);
      end
      step();
      chk("R5", "one-hot source", pin_clk_out, (c >= 1 && c <= 4));
    end

    // R7: tdm_inv ignored without override
    cfg_word = mk(1, 0, 3'd0, 16'd0, 0, 1, 0);
    pin_in = 1'b1; tdm_clk = 1'b1;
    step();
    chk("R7", "tdm_inv without override", serial_clk, 1'b0);

    // random phase
    for (int k = 0; k < 60; k++) begin
      cfg_word = {8'd0, 2'($urandom), 3'($urandom), 16'($urandom_range(0, 4)), 3'($urandom)};
      for (int j = 0; j < 300; j++) begin
        if ($urandom_range(0, 49) == 0) cfg_word[18:3] = 16'($urandom_range(0, 4));
        if ($urandom_range(0, 3) == 0) pin_in    = ~pin_in;
        if ($urandom_range(0, 2) == 0) synth_clk = ~synth_clk;
        if ($urandom_range(0, 1) == 0) osc_clk   = ~osc_clk;
        if ($urandom_range(0, 4) == 0) pll_clk   = ~pll_clk;
        if ($urandom_range(0, 2) == 0) tdm_clk   = ~tdm_clk;
        step();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule